// File: doc/BRIEF.md
# Panel power sequencer

This block brings a flat display panel up and down in a safe order. Three enables leave it: the panel supply, the pixel data interface and the backlight. A level request input asks for the panel to be on (high) or off (low). A free-running 1 ms strobe sets the time base. Four 16-bit configuration inputs give the gaps between steps. Power-up enables the supply, then the data interface, then the backlight. Power-down reverses that order, so the backlight is always the last output on and the first one off. This ordering prevents the white flash that a panel shows when its rails and signals come up or go down out of step.

The request may change at any point. When the request drops part way through power-up, the block shuts down only the outputs that are already on, in reverse order. When the request returns part way through power-down, the block resumes the on sequence from the outputs that are still on. No step is skipped and no gap is shortened. Three status outputs report whether the panel is fully on, fully off, or in transition.

Top module: `panel_pwr_seq`

## Requirements
- R1: After reset all three enables are 0, off_done_o is 1, and on_done_o and busy_o are 0.
- R2: With the request high and all outputs off, supply_en_o rises at the next clock edge. data_en_o follows once the supply-to-data delay has elapsed, and bl_en_o follows once the data-to-backlight delay has elapsed.
- R3: With the request low and the panel fully on, bl_en_o falls at the next clock edge. data_en_o falls once the backlight-to-data delay has elapsed, and supply_en_o falls once the data-to-supply delay has elapsed.
- R4: bl_en_o is never 1 while data_en_o is 0, and data_en_o is never 1 while supply_en_o is 0. At most one enable changes at any clock edge.
- R5: A wait of D counts only the clock edges at which tick_i is 1 that occur after the edge that entered the wait. The step happens at the max(D,1)-th such tick. Cycles without a tick do not advance the wait.
- R6: A delay of zero performs its step at the first counted tick.
- R7: If the request drops before the backlight is on, data_en_o (if it is on) falls at the next edge. supply_en_o then falls after the data-to-supply delay.
- R8: If the request rises during power-down, the on sequence resumes from the outputs still on. With supply and data on, the backlight turns on after the data-to-backlight delay. With only the supply on, data turns on after the supply-to-data delay and the rest follows.
- R9: on_done_o is 1 exactly when all three enables are 1, off_done_o is 1 exactly when all three are 0, and busy_o is 1 otherwise. Exactly one of the three is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwr_req_i | input | 1 | Level request: 1 = panel on, 0 = panel off |
| tick_i | input | 1 | One-cycle 1 ms time base strobe |
| on_dly_sup_i | input | 16 | Ticks from supply on to data on |
| on_dly_data_i | input | 16 | Ticks from data on to backlight on |
| off_dly_bl_i | input | 16 | Ticks from backlight off to data off |
| off_dly_data_i | input | 16 | Ticks from data off to supply off |
| supply_en_o | output | 1 | Panel supply enable |
| data_en_o | output | 1 | Pixel data interface enable |
| bl_en_o | output | 1 | Backlight enable |
| busy_o | output | 1 | Sequence in progress |
| on_done_o | output | 1 | All outputs on |
| off_done_o | output | 1 | All outputs off |

## Verification
The assertions check the following on every cycle:
- the enable nesting, and that at most one enable changes per edge;
- the consistency of the three status outputs;
- the conditions under which each edge may occur: a rising data or backlight enable and a falling supply enable need a tick, and the supply rise and the backlight fall need the request at the matching level.

Only the bench scenarios can show that each wait lasts exactly the programmed number of ticks, and that zero delays and the full 16-bit range behave as specified. The same holds for the abort and resume paths, which must land in the right place with the right delay selected. The bench compares these against a tick-counting reference model, using directed sequences and random request and tick patterns.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_UP_SUP,
    ST_UP_DATA,
    ST_ON,
    ST_DN_BL,
    ST_DN_DATA
  } pps_state_e;
endpackage

// File: rtl/pps_tick_timer.sv
module pps_tick_timer #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] limit_i,
  output logic             done_o
);
  logic [DLY_W-1:0] elapsed_q;
  logic [DLY_W:0]   next_cnt;

  assign next_cnt = {1'b0, elapsed_q} + 1'b1;
  // limit 0 also expires on the first tick
  assign done_o   = tick_i && (next_cnt >= {1'b0, limit_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                elapsed_q <= '0;
    else if (restart_i)         elapsed_q <= '0;
    else if (tick_i && !done_o) elapsed_q <= next_cnt[DLY_W-1:0];
  end
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
  import pps_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             done_i,
  input  logic [DLY_W-1:0] on_dly_sup_i,
  input  logic [DLY_W-1:0] on_dly_data_i,
  input  logic [DLY_W-1:0] off_dly_bl_i,
  input  logic [DLY_W-1:0] off_dly_data_i,
  output pps_state_e       state_o,
  output logic             restart_o,
  output logic [DLY_W-1:0] limit_o
);
  pps_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:     if (req_i) state_d = ST_UP_SUP;
      ST_UP_SUP:  if (!req_i) state_d = ST_DN_DATA;
                  else if (done_i) state_d = ST_UP_DATA;
      // backlight never came on: drop data now, skip its off gap
      ST_UP_DATA: if (!req_i) state_d = ST_DN_DATA;
                  else if (done_i) state_d = ST_ON;
      ST_ON:      if (!req_i) state_d = ST_DN_BL;
      ST_DN_BL:   if (req_i) state_d = ST_UP_DATA;
                  else if (done_i) state_d = ST_DN_DATA;
      ST_DN_DATA: if (req_i) state_d = ST_UP_SUP;
                  else if (done_i) state_d = ST_OFF;
      default:    state_d = ST_OFF;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_UP_SUP:  limit_o = on_dly_sup_i;
      ST_UP_DATA: limit_o = on_dly_data_i;
      ST_DN_BL:   limit_o = off_dly_bl_i;
      ST_DN_DATA: limit_o = off_dly_data_i;
      default:    limit_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign restart_o = (state_d != state_q);
  assign state_o   = state_q;
endmodule

// File: rtl/pps_out_map.sv
module pps_out_map
  import pps_pkg::*;
(
  input  pps_state_e state_i,
  output logic       supply_en_o,
  output logic       data_en_o,
  output logic       bl_en_o,
  output logic       busy_o,
  output logic       on_done_o,
  output logic       off_done_o
);
  always_comb begin
    unique case (state_i)
      ST_OFF:                {supply_en_o, data_en_o, bl_en_o} = 3'b000;
      ST_UP_SUP, ST_DN_DATA: {supply_en_o, data_en_o, bl_en_o} = 3'b100;
      ST_UP_DATA, ST_DN_BL:  {supply_en_o, data_en_o, bl_en_o} = 3'b110;
      ST_ON:                 {supply_en_o, data_en_o, bl_en_o} = 3'b111;
      default:               {supply_en_o, data_en_o, bl_en_o} = 3'b000;
    endcase
  end

  assign on_done_o  = (state_i == ST_ON);
  assign off_done_o = (state_i == ST_OFF);
  assign busy_o     = !on_done_o && !off_done_o;
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_req_i,
  input  logic             tick_i,
  input  logic [DLY_W-1:0] on_dly_sup_i,
  input  logic [DLY_W-1:0] on_dly_data_i,
  input  logic [DLY_W-1:0] off_dly_bl_i,
  input  logic [DLY_W-1:0] off_dly_data_i,
  output logic             supply_en_o,
  output logic             data_en_o,
  output logic             bl_en_o,
  output logic             busy_o,
  output logic             on_done_o,
  output logic             off_done_o
);
  pps_state_e       state;
  logic             restart;
  logic             done;
  logic [DLY_W-1:0] limit;

  pps_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_i         (pwr_req_i),
    .done_i        (done),
    .on_dly_sup_i  (on_dly_sup_i),
    .on_dly_data_i (on_dly_data_i),
    .off_dly_bl_i  (off_dly_bl_i),
    .off_dly_data_i(off_dly_data_i),
    .state_o       (state),
    .restart_o     (restart),
    .limit_o       (limit)
  );

  pps_tick_timer #(.DLY_W(DLY_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .tick_i   (tick_i),
    .limit_i  (limit),
    .done_o   (done)
  );

  pps_out_map u_map (
    .state_i    (state),
    .supply_en_o(supply_en_o),
    .data_en_o  (data_en_o),
    .bl_en_o    (bl_en_o),
    .busy_o     (busy_o),
    .on_done_o  (on_done_o),
    .off_done_o (off_done_o)
  );
endmodule

// File: rtl/pps_checker.sv
module pps_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic pwr_req_i,
  input logic tick_i,
  input logic supply_en_o,
  input logic data_en_o,
  input logic bl_en_o,
  input logic busy_o,
  input logic on_done_o,
  input logic off_done_o
);
  logic [2:0] en;
  assign en = {supply_en_o, data_en_o, bl_en_o};

  a_r4_bl_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bl_en_o |-> data_en_o) else $error("R4 backlight without data");

  a_r4_data_needs_supply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_en_o |-> supply_en_o) else $error("R4 data without supply");

  a_r4_one_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(en ^ $past(en)) <= 1) else $error("R4 two enables changed");

  a_r2_supply_on_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(supply_en_o) |-> $past(pwr_req_i)) else $error("R2 supply rose without request");

  a_r5_data_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(data_en_o) |-> ($past(tick_i) && $past(pwr_req_i)))
    else $error("R5 data rose without tick");

  a_r5_bl_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bl_en_o) |-> ($past(tick_i) && $past(pwr_req_i) && $past(data_en_o)))
    else $error("R5 backlight rose without tick");

  a_r3_supply_off_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(supply_en_o) |-> ($past(tick_i) && !$past(pwr_req_i) && !$past(data_en_o)))
    else $error("R3 supply fell out of order");

  a_r3_bl_off_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bl_en_o) |-> !$past(pwr_req_i)) else $error("R3 backlight fell with request high");

  a_r9_status_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({busy_o, on_done_o, off_done_o})) else $error("R9 status not one-hot");

  a_r9_status_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (on_done_o == (&en)) && (off_done_o == !(|en))) else $error("R9 status mismatch");
endmodule

bind panel_pwr_seq pps_checker u_pps_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_req_i  (pwr_req_i),
  .tick_i     (tick_i),
  .supply_en_o(supply_en_o),
  .data_en_o  (data_en_o),
  .bl_en_o    (bl_en_o),
  .busy_o     (busy_o),
  .on_done_o  (on_done_o),
  .off_done_o (off_done_o)
);

// File: tb/tb_panel_pwr_seq.sv
`timescale 1ns/1ps
module tb_panel_pwr_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwr_req = 1'b0;
  logic        tick = 1'b0;
  logic [15:0] d_on1 = '0, d_on2 = '0, d_off1 = '0, d_off2 = '0;
  logic        sup, dat, bl, busy, on_done, off_done;

  int errs = 0;
  int nchk = 0;
  int cyc_cnt = 0;
  int m_st = 0;
  int m_cnt = 0;
  string cur_tag = "R5";

  always #2.5 clk_i = ~clk_i;

  panel_pwr_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwr_req_i(pwr_req), .tick_i(tick),
    .on_dly_sup_i(d_on1), .on_dly_data_i(d_on2),
    .off_dly_bl_i(d_off1), .off_dly_data_i(d_off2),
    .supply_en_o(sup), .data_en_o(dat), .bl_en_o(bl),
    .busy_o(busy), .on_done_o(on_done), .off_done_o(off_done)
  );

  // model stages: 0 off,1 up-supply,2 up-data,3 on,4 down-bl,5 down-data
  function automatic logic [2:0] exp_en(int st);
    case (st)
      1, 5:    return 3'b100;
      2, 4:    return 3'b110;
      3:       return 3'b111;
      default: return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] exp_stat(int st);
    if (st == 0) return 3'b001;
    if (st == 3) return 3'b010;
    return 3'b100;
  endfunction

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    nchk++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %b expected %b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model_step(logic req, logic tk);
    int lim;
    int nxt;
    case (m_st)
      1: begin lim = d_on1;  nxt = 2; end
      2: begin lim = d_on2;  nxt = 3; end
      4: begin lim = d_off1; nxt = 5; end
      5: begin lim = d_off2; nxt = 0; end
      default: begin lim = 0; nxt = m_st; end
    endcase
    if (m_st == 0) begin
      if (req) begin m_st = 1; m_cnt = 0; end
    end else if (m_st == 3) begin
      if (!req) begin m_st = 4; m_cnt = 0; end
    end else if ((m_st == 1 || m_st == 2) && !req) begin
      m_st = 5; m_cnt = 0;
    end else if (m_st == 4 && req) begin
      m_st = 2; m_cnt = 0;
    end else if (m_st == 5 && req) begin
      m_st = 1; m_cnt = 0;
    end else if (tk) begin
      m_cnt++;
      if (m_cnt >= ((lim == 0) ? 1 : lim)) begin m_st = nxt; m_cnt = 0; end
    end
  endtask

  // drive at a falling edge, let one rising edge pass, compare at next falling edge
  task automatic cyc(logic req, logic tk);
    pwr_req = req;
    tick = tk;
    model_step(req, tk);
    @(negedge clk_i);
    chk(cur_tag, {sup, dat, bl}, exp_en(m_st));
    chk("R9", {busy, on_done, off_done}, exp_stat(m_st));
  endtask

  task automatic set_dly(int a, int b, int c, int d);
    d_on1 = 16'(a); d_on2 = 16'(b); d_off1 = 16'(c); d_off2 = 16'(d);
  endtask

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt > 150000) begin
      errs++;
      nchk++;
      $display("FAIL watchdog: got %0d cycles expected at most 150000", cyc_cnt);
      $display("  Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk("R1", {sup, dat, bl}, 3'b000);
    chk("R1", {busy, on_done, off_done}, 3'b001);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", {sup, dat, bl}, 3'b000);
    chk("R1", {busy, on_done, off_done}, 3'b001);

    // R2 / R5 / R6: on delays 3 then 0, ticks with gaps
    cur_tag = "R2";
    set_dly(3, 0, 2, 1);
    cyc(1, 0); chk("R2", {sup, dat, bl}, 3'b100);
    cyc(1, 1); cyc(1, 0); cyc(1, 0); cyc(1, 1);
    chk("R5", {sup, dat, bl}, 3'b100);
    cyc(1, 1); chk("R2", {sup, dat, bl}, 3'b110);
    cyc(1, 0); chk("R6", {sup, dat, bl}, 3'b110);
    cyc(1, 1); chk("R6", {sup, dat, bl}, 3'b111);
    cyc(1, 1); chk("R9", {busy, on_done, off_done}, 3'b010);

    // R3: off delays 2 then 1
    cur_tag = "R3";
    cyc(0, 0); chk("R3", {sup, dat, bl}, 3'b110);
    cyc(0, 1); chk("R3", {sup, dat, bl}, 3'b110);
    cyc(0, 1); chk("R3", {sup, dat, bl}, 3'b100);
    cyc(0, 1); chk("R3", {sup, dat, bl}, 3'b000);

    // R7: abort while supply only
    cur_tag = "R7";
    set_dly(4, 5, 3, 2);
    cyc(1, 1); cyc(1, 1); chk("R7", {sup, dat, bl}, 3'b100);
    cyc(0, 0); chk("R7", {sup, dat, bl}, 3'b100);
    cyc(0, 1); chk("R7", {sup, dat, bl}, 3'b100);
    cyc(0, 1); chk("R7", {sup, dat, bl}, 3'b000);
    // R7: abort while supply and data
    set_dly(1, 5, 3, 2);
    cyc(1, 0); cyc(1, 1); chk("R7", {sup, dat, bl}, 3'b110);
    cyc(1, 1); cyc(0, 0); chk("R7", {sup, dat, bl}, 3'b100);
    cyc(0, 1); cyc(0, 1); chk("R7", {sup, dat, bl}, 3'b000);

    // R8: resume from down-bl and from down-data
    cur_tag = "R8";
    set_dly(1, 2, 3, 5);
    cyc(1, 0); cyc(1, 1); cyc(1, 1); cyc(1, 1);
    chk("R8", {sup, dat, bl}, 3'b111);
    cyc(0, 0); cyc(0, 1); cyc(1, 0); chk("R8", {sup, dat, bl}, 3'b110);
    cyc(1, 1); chk("R8", {sup, dat, bl}, 3'b110);
    cyc(1, 1); chk("R8", {sup, dat, bl}, 3'b111);
    cyc(0, 0); cyc(0, 1); cyc(0, 1); cyc(0, 1);
    chk("R8", {sup, dat, bl}, 3'b100);
    cyc(1, 0); chk("R8", {sup, dat, bl}, 3'b100);
    cyc(1, 1); chk("R8", {sup, dat, bl}, 3'b110);
    cyc(1, 1); cyc(1, 1); chk("R8", {sup, dat, bl}, 3'b111);

    // R4 / R5: random requests, ticks and delays
    cur_tag = "R5";
    for (int i = 0; i < 30000; i++) begin
      logic rq;
      if ((m_st == 0 || m_st == 3) && ($urandom % 40) == 0)
        set_dly($urandom % 8, $urandom % 8, $urandom % 8, $urandom % 8);
      rq = pwr_req;
      if (($urandom % 30) == 0) rq = !rq;
      cyc(rq, ($urandom % 3) == 0);
    end
    cur_tag = "R4";
    for (int i = 0; i < 200; i++) cyc(1'b0, 1'b1);
    chk("R4", {sup, dat, bl}, 3'b000);

    // R2 / R3: typical long delays, one tick per cycle
    set_dly(30, 500, 150, 30);
    cur_tag = "R2";
    for (int i = 0; i < 530; i++) cyc(1'b1, 1'b1);
    chk("R2", {sup, dat, bl}, 3'b110);
    cyc(1, 1); chk("R2", {sup, dat, bl}, 3'b111);
    cur_tag = "R3";
    for (int i = 0; i < 180; i++) cyc(1'b0, 1'b1);
    chk("R3", {sup, dat, bl}, 3'b100);
    cyc(0, 1); chk("R3", {sup, dat, bl}, 3'b000);

    $display("  Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule